// File: doc/BRIEF.md
# Shadow-RAM Broadcast Coefficient Loader

This block stages filter coefficient words in a private shadow memory and later pushes them, in one pass, into any subset of eight target coefficient RAMs. A host fills the shadow memory one word at a time. It sets a pointer register, then writes a data register, and the pointer advances by itself after each stored word. The host then chooses the target set with an 8-bit mask, the pass length in units of three words, and the event that starts the pass.

When the chosen event arrives, the controller latches the mask and the length. It then holds in a waiting state until none of the selected targets reports busy. After that it streams shadow words 0 to 3·LEN−1, one per clock, to the same address of every selected target at once. Live coefficients are therefore replaced only while their RAMs are idle, and the pass takes the same number of cycles whatever the number of targets. On completion a sticky done bit is set, and an interrupt line follows it when enabled.

The controller has four states:
- `ST_IDLE`: waits for the selected event. On the event it moves to `ST_WAIT`, or straight to `ST_DONE` when the pass is empty.
- `ST_WAIT`: holds until all selected targets are idle, then moves to `ST_COPY`.
- `ST_COPY`: issues one shadow read per cycle. After the last read it moves to `ST_DONE`.
- `ST_DONE`: lasts one cycle. The last write leaves the block, the done bit is set, and the state returns to `ST_IDLE`.

Top module: `coef_bcast_loader`

## Requirements
- R1: A host write to register 1 stores `reg_wdata` at the shadow pointer and advances the pointer by one, wrapping from 767 to 0. Register 0 sets the pointer when written and returns it when read.
- R2: Register 2 bits [7:0] select the targets. A target whose bit is clear at the moment of the trigger receives no write during that pass.
- R3: A pass writes exactly 3·LEN words, where LEN is register 3 bits [7:0]. The words go out at consecutive target addresses 0 to 3·LEN−1, one per cycle, and each carries the shadow word at the same address.
- R4: Each pass cycle drives `tgt_we` equal to the latched mask in full, so every enabled target gets the same word at the same address in the same cycle.
- R5: Register 4 bits [2:0] choose the start event. Code 1 is a host write of 1 to register 5 bit 0. Code 2 is `timer_tick`, code 3 is `sync_a` and code 4 is `sync_b`. Codes 0 and 5 to 7 never start a pass, and events from sources that are not selected are ignored.
- R6: After the trigger, copying begins only when every masked `tgt_busy` bit is low. Busy bits of unmasked targets have no effect.
- R7: Completion sets status bit 6, which is register 6. The bit stays set until the host writes register 6 with bit 6 high.
- R8: `irq` equals status bit 6 ANDed with the copy of register 7 bit 6 that was taken when register 4 was last written.
- R9: A start event that arrives while a pass is waiting or copying is ignored, so the pass is not restarted or repeated.
- R10: A write to register 1 while waiting or copying stores nothing and leaves the pointer unchanged. It sets sticky status bit 0, which is cleared by writing register 6 with bit 0 high.
- R11: A pass with a zero mask or zero LEN writes nothing, and its done bit is visible two clock edges after the trigger edge.
- R12: For a non-empty pass, the done bit is visible 3·LEN+3+W edges after the trigger edge, counting the trigger edge itself as the first. W is the number of extra edges spent waiting for busy targets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Single-cycle register write strobe |
| reg_rd | input | 1 | Single-cycle register read strobe; data appears one cycle later |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, registered |
| timer_tick | input | 1 | Timer start event |
| sync_a | input | 1 | Synchronization input A start event |
| sync_b | input | 1 | Synchronization input B start event |
| tgt_busy | input | 8 | Per-target busy flags |
| tgt_we | output | 8 | Per-target write enables |
| tgt_addr | output | 10 | Address shared by all target writes |
| tgt_wdata | output | 16 | Word shared by all target writes |
| irq | output | 1 | Completion interrupt |

## Verification
A trigger presented before edge E0 gives the first target write after the second edge on which `ST_WAIT` finds the targets idle, and the done bit and `irq` become visible after edge E(3·LEN+2+W). For an empty pass they are visible after E1. Register reads return data one edge after the strobe, and target writes appear the edge after their shadow read. The bench therefore drives every input on a falling edge and samples on falling edges. It counts falling edges from the trigger and compares the count at which `irq` first rises with the value computed from R11 and R12. A falling-edge monitor records every target write and checks the address order and the broadcast mask against the expected values.

// File: rtl/coefld_pkg.sv
package coefld_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_COPY,
        ST_DONE
    } xfer_state_t;

    localparam logic [3:0] RA_PTR  = 4'd0;
    localparam logic [3:0] RA_WORD = 4'd1;
    localparam logic [3:0] RA_MASK = 4'd2;
    localparam logic [3:0] RA_LEN  = 4'd3;
    localparam logic [3:0] RA_TRIG = 4'd4;
    localparam logic [3:0] RA_GO   = 4'd5;
    localparam logic [3:0] RA_STAT = 4'd6;
    localparam logic [3:0] RA_IEN  = 4'd7;

    localparam logic [2:0] TS_NONE  = 3'd0;
    localparam logic [2:0] TS_SOFT  = 3'd1;
    localparam logic [2:0] TS_TIMER = 3'd2;
    localparam logic [2:0] TS_SYNCA = 3'd3;
    localparam logic [2:0] TS_SYNCB = 3'd4;

    localparam int DONE_BIT = 6;
    localparam int ERR_BIT  = 0;

endpackage

// File: rtl/coefld_shadow.sv
module coefld_shadow #(
    parameter int DEPTH  = 768,
    parameter int DATA_W = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
        if (rd_en) begin
            rd_data <= mem[rd_addr];
        end
    end

endmodule

// File: rtl/coefld_regs.sv
module coefld_regs
    import coefld_pkg::*;
#(
    parameter int DEPTH   = 768,
    parameter int DATA_W  = 16,
    parameter int REG_W   = 16,
    parameter int NUM_TGT = 8,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int LEN_W  = $clog2(DEPTH / 3)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [3:0]         reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic               xfer_active,
    input  logic               done_pulse,
    output logic               sh_we,
    output logic [ADDR_W-1:0]  sh_waddr,
    output logic [DATA_W-1:0]  sh_wdata,
    output logic [NUM_TGT-1:0] tgt_mask,
    output logic [LEN_W-1:0]   xfer_len,
    output logic [2:0]         trig_sel,
    output logic               soft_go,
    output logic               irq
);

    logic [ADDR_W-1:0] ptr;
    logic              ien;
    logic              ien_armed;
    logic              done_flag;
    logic              err_flag;
    logic [REG_W-1:0]  stat_v;

    logic wr_word;
    logic wr_stat;

    always_comb begin
        wr_word  = reg_wr && (reg_addr == RA_WORD);
        wr_stat  = reg_wr && (reg_addr == RA_STAT);
        sh_we    = wr_word && !xfer_active;
        sh_waddr = ptr;
        sh_wdata = reg_wdata[DATA_W-1:0];
        soft_go  = reg_wr && (reg_addr == RA_GO) && reg_wdata[0];
        irq      = done_flag && ien_armed;
        stat_v           = '0;
        stat_v[DONE_BIT] = done_flag;
        stat_v[ERR_BIT]  = err_flag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr       <= '0;
            tgt_mask  <= '0;
            xfer_len  <= '0;
            trig_sel  <= TS_NONE;
            ien       <= 1'b0;
            ien_armed <= 1'b0;
            done_flag <= 1'b0;
            err_flag  <= 1'b0;
            reg_rdata <= '0;
        end else begin
            if (reg_wr) begin
                unique case (reg_addr)
                    RA_PTR:  ptr <= reg_wdata[ADDR_W-1:0];
                    RA_WORD: begin
                        if (!xfer_active) begin
                            ptr <= (ptr == ADDR_W'(DEPTH - 1)) ? '0 : ptr + 1'b1;
                        end
                    end
                    RA_MASK: tgt_mask <= reg_wdata[NUM_TGT-1:0];
                    RA_LEN:  xfer_len <= reg_wdata[LEN_W-1:0];
                    RA_TRIG: begin
                        trig_sel  <= reg_wdata[2:0];
                        ien_armed <= ien;
                    end
                    RA_IEN:  ien <= reg_wdata[DONE_BIT];
                    default: ;
                endcase
            end
            if (done_pulse) begin
                done_flag <= 1'b1;
            end else if (wr_stat && reg_wdata[DONE_BIT]) begin
                done_flag <= 1'b0;
            end
            if (wr_word && xfer_active) begin
                err_flag <= 1'b1;
            end else if (wr_stat && reg_wdata[ERR_BIT]) begin
                err_flag <= 1'b0;
            end
            if (reg_rd) begin
                unique case (reg_addr)
                    RA_PTR:  reg_rdata <= REG_W'(ptr);
                    RA_MASK: reg_rdata <= REG_W'(tgt_mask);
                    RA_LEN:  reg_rdata <= REG_W'(xfer_len);
                    RA_TRIG: reg_rdata <= REG_W'(trig_sel);
                    RA_STAT: reg_rdata <= stat_v;
                    RA_IEN:  reg_rdata <= REG_W'(ien) << DONE_BIT;
                    default: reg_rdata <= '0;
                endcase
            end
        end
    end

    // R10
    blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_word && xfer_active) |=> (err_flag && $stable(ptr)));

    // R7
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && !(wr_stat && reg_wdata[DONE_BIT])) |=> done_flag);

    // R1
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_we && ptr != ADDR_W'(DEPTH - 1)) |=> (ptr == $past(ptr) + 1'b1));

endmodule

// File: rtl/coefld_fsm.sv
module coefld_fsm
    import coefld_pkg::*;
#(
    parameter int DEPTH   = 768,
    parameter int DATA_W  = 16,
    parameter int NUM_TGT = 8,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int LEN_W  = $clog2(DEPTH / 3),
    localparam int CNT_W  = ADDR_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         trig_sel,
    input  logic               soft_go,
    input  logic               timer_tick,
    input  logic               sync_a,
    input  logic               sync_b,
    input  logic [NUM_TGT-1:0] tgt_mask,
    input  logic [LEN_W-1:0]   xfer_len,
    input  logic [NUM_TGT-1:0] tgt_busy,
    output logic               rd_en,
    output logic [ADDR_W-1:0]  rd_addr,
    input  logic [DATA_W-1:0]  rd_data,
    output logic [NUM_TGT-1:0] tgt_we,
    output logic [ADDR_W-1:0]  tgt_addr,
    output logic [DATA_W-1:0]  tgt_wdata,
    output logic               xfer_active,
    output logic               done_pulse
);

    xfer_state_t state, nxt;

    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   total_lat;
    logic [CNT_W-1:0]   total_new;
    logic [NUM_TGT-1:0] mask_lat;
    logic               pipe_vld;
    logic [ADDR_W-1:0]  pipe_addr;
    logic               fire;
    logic               sel_idle;

    always_comb begin
        unique case (trig_sel)
            TS_SOFT:  fire = soft_go;
            TS_TIMER: fire = timer_tick;
            TS_SYNCA: fire = sync_a;
            TS_SYNCB: fire = sync_b;
            default:  fire = 1'b0;
        endcase
        total_new = CNT_W'(xfer_len) * CNT_W'(3);
        sel_idle  = ((tgt_busy & mask_lat) == '0);
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (fire) begin
                    nxt = (tgt_mask == '0 || xfer_len == '0) ? ST_DONE : ST_WAIT;
                end
            end
            ST_WAIT: if (sel_idle) nxt = ST_COPY;
            ST_COPY: if (cnt == total_lat - 1'b1) nxt = ST_DONE;
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // pass datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            total_lat <= '0;
            mask_lat  <= '0;
            pipe_vld  <= 1'b0;
            pipe_addr <= '0;
        end else begin
            pipe_vld <= 1'b0;
            if (state == ST_IDLE && fire) begin
                mask_lat  <= tgt_mask;
                total_lat <= total_new;
                cnt       <= '0;
            end
            if (state == ST_COPY) begin
                cnt       <= cnt + 1'b1;
                pipe_vld  <= 1'b1;
                pipe_addr <= cnt[ADDR_W-1:0];
            end
        end
    end

    // outputs
    always_comb begin
        rd_en       = (state == ST_COPY);
        rd_addr     = cnt[ADDR_W-1:0];
        tgt_we      = pipe_vld ? mask_lat : '0;
        tgt_addr    = pipe_addr;
        tgt_wdata   = rd_data;
        xfer_active = (state == ST_WAIT) || (state == ST_COPY);
        done_pulse  = (state == ST_DONE);
    end

    // R6
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !sel_idle) |=> (state == ST_WAIT));

    // R9
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COPY) |=> (state == ST_COPY || state == ST_DONE));

    // R3
    copy_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && $past(state) == ST_COPY) |-> (cnt == total_lat));

    // R11
    empty_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && fire && tgt_mask == '0) |=> (state == ST_DONE && tgt_we == '0));

    // R3
    we_after_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_we != '0) |-> ($past(state) == ST_COPY));

endmodule

// File: rtl/coef_bcast_loader.sv
module coef_bcast_loader
    import coefld_pkg::*;
#(
    parameter int DEPTH   = 768,
    parameter int DATA_W  = 16,
    parameter int REG_W   = 16,
    parameter int NUM_TGT = 8,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int LEN_W  = $clog2(DEPTH / 3)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [3:0]         reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic               timer_tick,
    input  logic               sync_a,
    input  logic               sync_b,
    input  logic [NUM_TGT-1:0] tgt_busy,
    output logic [NUM_TGT-1:0] tgt_we,
    output logic [ADDR_W-1:0]  tgt_addr,
    output logic [DATA_W-1:0]  tgt_wdata,
    output logic               irq
);

    logic               xfer_active;
    logic               done_pulse;
    logic               sh_we;
    logic [ADDR_W-1:0]  sh_waddr;
    logic [DATA_W-1:0]  sh_wdata;
    logic [NUM_TGT-1:0] tgt_mask;
    logic [LEN_W-1:0]   xfer_len;
    logic [2:0]         trig_sel;
    logic               soft_go;
    logic               rd_en;
    logic [ADDR_W-1:0]  rd_addr;
    logic [DATA_W-1:0]  rd_data;

    coefld_regs #(
        .DEPTH(DEPTH), .DATA_W(DATA_W), .REG_W(REG_W), .NUM_TGT(NUM_TGT)
    ) i_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .xfer_active(xfer_active), .done_pulse(done_pulse),
        .sh_we(sh_we), .sh_waddr(sh_waddr), .sh_wdata(sh_wdata),
        .tgt_mask(tgt_mask), .xfer_len(xfer_len), .trig_sel(trig_sel),
        .soft_go(soft_go), .irq(irq)
    );

    coefld_shadow #(
        .DEPTH(DEPTH), .DATA_W(DATA_W)
    ) i_shadow (
        .clk(clk),
        .wr_en(sh_we), .wr_addr(sh_waddr), .wr_data(sh_wdata),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    coefld_fsm #(
        .DEPTH(DEPTH), .DATA_W(DATA_W), .NUM_TGT(NUM_TGT)
    ) i_fsm (
        .clk(clk), .rst_n(rst_n),
        .trig_sel(trig_sel), .soft_go(soft_go),
        .timer_tick(timer_tick), .sync_a(sync_a), .sync_b(sync_b),
        .tgt_mask(tgt_mask), .xfer_len(xfer_len), .tgt_busy(tgt_busy),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .tgt_we(tgt_we), .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata),
        .xfer_active(xfer_active), .done_pulse(done_pulse)
    );

    // R8
    irq_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(done_pulse));

endmodule

// File: tb/test_coef_bcast_loader.sv
`timescale 1ns/1ps
module test_coef_bcast_loader;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        timer_tick = 1'b0;
    logic        sync_a = 1'b0;
    logic        sync_b = 1'b0;
    logic [7:0]  tgt_busy = '0;
    logic [7:0]  tgt_we;
    logic [9:0]  tgt_addr;
    logic [15:0] tgt_wdata;
    logic        irq;

    always #2.5 clk = ~clk;

    coef_bcast_loader i_coef_bcast_loader (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .timer_tick(timer_tick), .sync_a(sync_a), .sync_b(sync_b),
        .tgt_busy(tgt_busy), .tgt_we(tgt_we), .tgt_addr(tgt_addr),
        .tgt_wdata(tgt_wdata), .irq(irq)
    );

    int n_chk = 0;
    int n_bad = 0;

    logic [15:0] sh [768];
    logic [15:0] tmem [8][768];
    int          wcount [8];
    int          we_cycles = 0;
    int          seq_bad = 0;
    logic [7:0]  exp_mask = '0;
    int          exp_addr = 0;
    int          sh_ptr = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && tgt_we != '0) begin
            we_cycles++;
            if (tgt_we != exp_mask) seq_bad++;
            if (int'(tgt_addr) != exp_addr) seq_bad++;
            exp_addr++;
            for (int t = 0; t < 8; t++) begin
                if (tgt_we[t]) begin
                    tmem[t][tgt_addr] = tgt_wdata;
                    wcount[t]++;
                end
            end
        end
    end

    task automatic reg_write(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic mon_clear(input logic [7:0] m);
        we_cycles = 0; seq_bad = 0; exp_addr = 0; exp_mask = m;
        for (int t = 0; t < 8; t++) begin
            wcount[t] = 0;
            for (int i = 0; i < 768; i++) tmem[t][i] = 'x;
        end
    endtask

    // host shadow write, mirrored in the bench model (R1)
    task automatic sh_write(input logic [15:0] d);
        reg_write(4'd1, d);
        sh[sh_ptr] = d;
        sh_ptr = (sh_ptr == 767) ? 0 : sh_ptr + 1;
    endtask

    task automatic load_shadow(input int n);
        reg_write(4'd0, 16'd0);
        sh_ptr = 0;
        for (int i = 0; i < n; i++) sh_write(16'($urandom));
    endtask

    // drive the selected start event for the edge that follows (caller ends it)
    task automatic drive_event(input int src, input bit v);
        case (src)
            1: begin reg_wr = v; reg_addr = 4'd5; reg_wdata = 16'h0001; end
            2: timer_tick = v;
            3: sync_a = v;
            4: sync_b = v;
            default: ;
        endcase
    endtask

    function automatic int exp_latency(input logic [7:0] m, input int len, input int b);
        if (m == 0 || len == 0) return 2;
        return 3 * len + 3 + ((b > 0) ? b - 1 : 0);
    endfunction

    task automatic check_data(input logic [7:0] m, input int n, input string tag);
        int bad_words = 0;
        for (int t = 0; t < 8; t++) begin
            if (m[t]) begin
                chk(wcount[t] == n, {tag, " R3 per-target count"}, wcount[t], n);
                for (int i = 0; i < n; i++) if (tmem[t][i] !== sh[i]) bad_words++;
            end else begin
                chk(wcount[t] == 0, {tag, " R2 unmasked target untouched"}, wcount[t], 0);
            end
        end
        chk(bad_words == 0, {tag, " R3 copied words match shadow"}, bad_words, 0);
        chk(seq_bad == 0, {tag, " R4 broadcast mask and address order"}, seq_bad, 0);
        chk(we_cycles == n, {tag, " R3 write cycles"}, we_cycles, n);
    endtask

    task automatic run_xfer(input logic [7:0] m, input int len, input int src,
                            input int b, input logic [7:0] other_busy, input bit ien);
        int n;
        int k;
        int lat;
        logic [15:0] rv;
        n   = (m == 0) ? 0 : 3 * len;
        lat = exp_latency(m, len, b);
        reg_write(4'd2, {8'd0, m});
        reg_write(4'd3, 16'(len));
        reg_write(4'd7, ien ? 16'h0040 : 16'h0000);
        reg_write(4'd4, 16'(src));
        mon_clear(m);
        @(negedge clk);
        tgt_busy = (other_busy & ~m) | ((b > 0) ? m : 8'h00);
        drive_event(src, 1'b1);
        k = 0;
        while (k < lat + 4) begin
            @(negedge clk);
            k++;
            if (k == 1) drive_event(src, 1'b0);
            if (k == b) tgt_busy = tgt_busy & ~m;
            if (ien && irq) break;
            if (!ien) chk(irq == 1'b0, "R8 irq stays low when not armed", int'(irq), 0);
        end
        if (ien) begin
            chk(k == lat, "R12/R11 done latency", k, lat);
        end
        reg_read(4'd6, rv);
        chk(rv[6] == 1'b1, "R7 done bit set", int'(rv[6]), 1);
        check_data(m, n, "xfer");
        reg_write(4'd6, 16'h0041);
        reg_read(4'd6, rv);
        chk(rv[6] == 1'b0 && irq == 1'b0, "R7 done cleared by W1C", int'(rv[6]), 0);
        tgt_busy = '0;
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] rv;
        int k;
        void'($urandom(32'h5EED_C0EF));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk(irq == 1'b0 && tgt_we == '0, "R8 reset irq/we", int'(irq), 0);
        reg_read(4'd6, rv); chk(rv == 16'h0, "R7 reset status", int'(rv), 0);
        reg_read(4'd2, rv); chk(rv == 16'h0, "R2 reset mask", int'(rv), 0);
        reg_read(4'd0, rv); chk(rv == 16'h0, "R1 reset pointer", int'(rv), 0);

        // R1 pointer increment and wrap
        reg_write(4'd0, 16'd5); sh_ptr = 5;
        sh_write(16'h1111); sh_write(16'h2222);
        reg_read(4'd0, rv); chk(rv == 16'd7, "R1 pointer increments", int'(rv), 7);
        reg_write(4'd0, 16'd767); sh_ptr = 767;
        sh_write(16'h3333);
        reg_read(4'd0, rv); chk(rv == 16'd0, "R1 pointer wraps", int'(rv), 0);

        // R5 unselected sources and non-codes
        load_shadow(6);
        reg_write(4'd2, 16'h00FF);
        reg_write(4'd3, 16'd2);
        reg_write(4'd4, 16'd3);
        mon_clear(8'hFF);
        for (int s = 1; s <= 4; s++) begin
            if (s != 3) begin
                @(negedge clk); drive_event(s, 1'b1);
                @(negedge clk); drive_event(s, 1'b0);
            end
        end
        repeat (10) @(negedge clk);
        reg_read(4'd6, rv);
        chk(rv[6] == 1'b0 && we_cycles == 0, "R5 unselected sources ignored", we_cycles, 0);
        for (int code = 0; code < 8; code++) begin
            if (code == 0 || code > 4) begin
                reg_write(4'd4, 16'(code));
                @(negedge clk); sync_a = 1'b1; timer_tick = 1'b1; sync_b = 1'b1;
                @(negedge clk); sync_a = 1'b0; timer_tick = 1'b0; sync_b = 1'b0;
                drive_event(1, 1'b1);
                @(negedge clk); drive_event(1, 1'b0);
            end
        end
        repeat (10) @(negedge clk);
        reg_read(4'd6, rv);
        chk(rv[6] == 1'b0 && we_cycles == 0, "R5 codes 0,5,6,7 never start", we_cycles, 0);

        // R9/R10 blocked write and ignored retrigger while waiting
        load_shadow(6);
        reg_write(4'd2, 16'h0005);
        reg_write(4'd3, 16'd2);
        reg_write(4'd7, 16'h0040);
        reg_write(4'd4, 16'd1);
        mon_clear(8'h05);
        @(negedge clk); tgt_busy = 8'h04;
        drive_event(1, 1'b1);
        @(negedge clk); drive_event(1, 1'b0);
        repeat (3) @(negedge clk);
        reg_write(4'd1, 16'hDEAD);
        reg_write(4'd5, 16'h0001);
        reg_read(4'd6, rv);
        chk(rv[0] == 1'b1, "R10 error flag on blocked write", int'(rv[0]), 1);
        tgt_busy = '0;
        repeat (40) @(negedge clk);
        check_data(8'h05, 6, "R10/R9 blocked");
        reg_read(4'd0, rv); chk(rv == 16'd6, "R10 pointer unchanged", int'(rv), 6);
        reg_write(4'd6, 16'h0041);
        reg_read(4'd6, rv); chk(rv == 16'd0, "R10 error W1C", int'(rv), 0);

        // R11 empty passes
        run_xfer(8'h00, 4, 2, 0, 8'h00, 1'b1);
        run_xfer(8'hFF, 0, 3, 0, 8'h00, 1'b1);

        // R6 busy unmasked ignored, masked busy waited for
        load_shadow(9);
        run_xfer(8'h0F, 3, 4, 0, 8'hF0, 1'b1);
        run_xfer(8'h81, 3, 1, 6, 8'h7E, 1'b1);
        // R8 not armed
        run_xfer(8'h22, 3, 2, 2, 8'h00, 1'b0);

        // constrained random passes
        for (int it = 0; it < 16; it++) begin
            int len;
            logic [7:0] m;
            len = 1 + int'($urandom % 30);
            m   = 8'($urandom);
            if (it % 7 == 3) m = 8'h00;
            load_shadow(3 * len);
            run_xfer(m, len, 1 + int'($urandom % 4), int'($urandom % 6),
                     8'($urandom), 1'b1);
        end

        // full-length pass: 255 * 3 = 765 words
        load_shadow(765);
        run_xfer(8'hA5, 255, 2, 0, 8'h00, 1'b1);

        k = 0;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad + k);
        $finish;
    end

endmodule